// File: doc/BRIEF.md
# ATM Transmit Cell Header Check and Payload Scrambler

This block sits on the transmit side of a cell-based link. Cells arrive as a stream of 53 bytes, one byte per clock, and a start-of-cell flag marks the first byte. The block computes an 8-bit cyclic check over the four leading header octets. It can add a fixed coset pattern to that check and can XOR it with a software error mask, which lets test equipment inject header errors on purpose. The block then writes the result into octet five. When enabled, the 48 payload octets are scrambled with a self-synchronizing x^43+1 scrambler. The header octets are never scrambled.

Software reaches two 8-bit registers through a simple write port with a combinational read port. One is a control register at address 0x60 and the other is an error mask register at address 0x62. New settings are latched at each cell boundary. This means every cell is processed with one consistent set of settings. The output stream is the input stream delayed by exactly one registered stage, and the start-of-cell flag is delayed with it.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: After reset, a read of address 0x60 returns 0x72 and a read of 0x62 returns 0x00. Any other address reads 0x00. Bit 0 of the control register always reads 0, and control bits 7..1 read back what was written.
- R2: With HEC insertion enabled (control bit 5 = 1), octet 5 of the output carries the CRC-8 of octets 1-4. The CRC uses generator x^8+x^2+x+1, is computed MSB first and starts from zero. Header 00 00 00 01 gives 0x07.
- R3: With HEC insertion and coset enabled (control bit 6 = 1), the inserted byte is the CRC XOR 0x55. For example, header 00 00 00 01 gives 0x52.
- R4: With HEC insertion enabled, the inserted byte is further XORed with the error mask register.
- R5: With HEC insertion disabled, octet 5 leaves the block equal to the input octet 5, and neither the coset nor the mask has any effect.
- R6: Header octets 1-4 pass through unchanged in every mode.
- R7: With control bit 7 = 1, each payload bit (octets 6-53, MSB first) is output as the input bit XOR the output bit 43 positions earlier. The scrambler history is all zero after reset. With bit 7 = 0, payload octets pass through unchanged.
- R8: The scrambler history carries over from cell to cell and advances only on scrambled payload bits.
- R9: Every output byte, and the start-of-cell flag, appears exactly one clock after the matching input.
- R10: A start-of-cell flag in the middle of a cell restarts octet counting at octet 1.
- R11: Register writes affect only cells that start after the write. A write made during a cell leaves that cell's processing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Input cell byte, one per clock |
| soc_i | input | 1 | Marks the first octet of a cell |
| data_o | output | 8 | Processed cell byte |
| soc_o | output | 1 | Start-of-cell flag aligned with data_o |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
The checker watches several properties on every clock:
- header octets 1-4 pass through unchanged;
- the start-of-cell flag has one cycle of delay;
- octet 5 and the payload pass through unchanged when insertion or scrambling is disabled;
- the octet position stays in range;
- the scrambler history is frozen on header octets;
- the latched settings change only at a cell boundary.

Only the bench scenarios can show the arithmetic values: the CRC, coset and mask combinations, the scrambled payload across two consecutive cells, the register reset and read-back values, and the outcome of mid-cell writes and mid-cell start-of-cell resynchronisation.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int BYTE_W   = 8;
  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = 4;
  localparam int POS_W    = $clog2(CELL_LEN);
  localparam int SCR_W    = 43;

  localparam logic [BYTE_W-1:0] HEC_POLY  = 8'h07;
  localparam logic [BYTE_W-1:0] COSET_VAL = 8'h55;
  localparam logic [BYTE_W-1:0] CTL_RST   = 8'h72;
  localparam logic [BYTE_W-1:0] CTL_ADDR  = 8'h60;
  localparam logic [BYTE_W-1:0] MASK_ADDR = 8'h62;

  localparam int BIT_SCR   = 7;
  localparam int BIT_COSET = 6;
  localparam int BIT_INS   = 5;

  typedef struct packed {
    logic [SCR_W-1:0]  st;
    logic [BYTE_W-1:0] q;
  } scr_res_t;

  function automatic logic [BYTE_W-1:0] crc8_step(logic [BYTE_W-1:0] c_in,
                                                  logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      fb = c[BYTE_W-1] ^ d[i];
      c  = {c[BYTE_W-2:0], 1'b0} ^ (fb ? HEC_POLY : '0);
    end
    return c;
  endfunction

  // self-synchronizing: out = in ^ out delayed by SCR_W bits
  function automatic scr_res_t scr_step(logic [SCR_W-1:0] st_in,
                                        logic [BYTE_W-1:0] d);
    scr_res_t r;
    logic o;
    r.st = st_in;
    r.q  = '0;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      o      = d[i] ^ r.st[SCR_W-1];
      r.q[i] = o;
      r.st   = {r.st[SCR_W-2:0], o};
    end
    return r;
  endfunction
endpackage

// File: rtl/atm_tx_regs.sv
module atm_tx_regs
  import atm_tx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] ctl_o,
  output logic [BYTE_W-1:0] mask_o
);
  logic [BYTE_W-1:1] ctl_q;
  logic [BYTE_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_RST[BYTE_W-1:1];
      mask_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(CTL_ADDR))  ctl_q  <= wdata_i[BYTE_W-1:1];
      if (addr_i == AW'(MASK_ADDR)) mask_q <= wdata_i;
    end
  end

  assign ctl_o  = {ctl_q, 1'b0};
  assign mask_o = mask_q;

  always_comb begin
    if (addr_i == AW'(CTL_ADDR))       rdata_o = {ctl_q, 1'b0};
    else if (addr_i == AW'(MASK_ADDR)) rdata_o = mask_q;
    else                               rdata_o = '0;
  end
endmodule

// File: rtl/atm_tx_hec.sv
module atm_tx_hec
  import atm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] crc_o
);
  logic [BYTE_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      crc_q <= '0;
    else if (pos_i < POS_W'(HDR_LEN))
      crc_q <= crc8_step((pos_i == '0) ? '0 : crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/atm_tx_scr.sv
module atm_tx_scr
  import atm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [SCR_W-1:0]  state_o
);
  logic [SCR_W-1:0] st_q;
  scr_res_t         res;

  assign res = scr_step(st_q, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (upd_i) st_q <= res.st;
  end

  assign data_o  = res.q;
  assign state_o = st_q;
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              soc_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              soc_o,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o
);
  logic [POS_W-1:0]  cnt_q, pos;
  logic [BYTE_W-1:0] ctl_q, mask_q, ctl_act, mask_act;
  logic [BYTE_W-1:0] crc, hec_fin, scr_data, out_d;
  logic [SCR_W-1:0]  scr_st;
  logic              ins_act, cos_act, scr_act, scr_upd;

  assign pos = soc_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else
      cnt_q <= (pos == POS_W'(CELL_LEN-1)) ? '0 : pos + 1'b1;
  end

  atm_tx_regs #(.AW(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctl_o  (ctl_q),
    .mask_o (mask_q)
  );

  // settings latched once per cell, at octet 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_act  <= CTL_RST;
      mask_act <= '0;
    end else if (pos == '0) begin
      ctl_act  <= ctl_q;
      mask_act <= mask_q;
    end
  end

  assign ins_act = ctl_act[BIT_INS];
  assign cos_act = ctl_act[BIT_COSET];
  assign scr_act = ctl_act[BIT_SCR];

  atm_tx_hec u_hec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pos_i (pos),
    .data_i(data_i),
    .crc_o (crc)
  );

  assign scr_upd = scr_act && (pos > POS_W'(HDR_LEN));

  atm_tx_scr u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (scr_upd),
    .data_i (data_i),
    .data_o (scr_data),
    .state_o(scr_st)
  );

  assign hec_fin = crc ^ (cos_act ? COSET_VAL : '0) ^ mask_act;

  always_comb begin
    if (pos == POS_W'(HDR_LEN) && ins_act) out_d = hec_fin;
    else if (scr_upd)                      out_d = scr_data;
    else                                   out_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      soc_o  <= 1'b0;
    end else begin
      data_o <= out_d;
      soc_o  <= soc_i;
    end
  end
endmodule

// File: rtl/atm_tx_cell_chk.sv
module atm_tx_cell_chk
  import atm_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] data_i,
  input logic              soc_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              soc_o,
  input logic [POS_W-1:0]  pos_i,
  input logic [BYTE_W-1:0] ctl_act_i,
  input logic [SCR_W-1:0]  scr_st_i
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_HDR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pos_i) < POS_W'(HDR_LEN) |-> data_o == $past(data_i)); // R6
  AST_SOC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> soc_o == $past(soc_i)); // R9
  AST_NOINS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pos_i) == POS_W'(HDR_LEN) && !$past(ctl_act_i[BIT_INS])
    |-> data_o == $past(data_i)); // R5
  AST_SCR_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pos_i) > POS_W'(HDR_LEN) && !$past(ctl_act_i[BIT_SCR])
    |-> data_o == $past(data_i)); // R7
  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_i < POS_W'(CELL_LEN)); // R10
  AST_SCR_HDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pos_i) <= POS_W'(HDR_LEN) |-> scr_st_i == $past(scr_st_i)); // R8
  AST_CTL_CELL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pos_i) != '0 |-> ctl_act_i == $past(ctl_act_i)); // R11
endmodule

bind atm_tx_cell_proc atm_tx_cell_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .soc_i    (soc_i),
  .data_o   (data_o),
  .soc_o    (soc_o),
  .pos_i    (pos),
  .ctl_act_i(ctl_act),
  .scr_st_i (scr_st)
);

// File: tb/sim_atm_tx_cell_proc.sv
module sim_atm_tx_cell_proc;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       soc_i = 1'b0;
  logic [7:0] data_o;
  logic       soc_o;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]  got;
  logic        got_soc;
  logic [42:0] hist = '0;

  always #2.5 clk_i = ~clk_i;

  atm_tx_cell_proc u0 (.*);

  // {header, ctl, mask, octet5 in, expected octet5}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0001, 8'h60, 8'h00, 8'h00, 8'h52},  // R3
    {32'h0000_0001, 8'h20, 8'h00, 8'h00, 8'h07},  // R2
    {32'h0000_0000, 8'h60, 8'h00, 8'h00, 8'h55},  // R3
    {32'h0000_0001, 8'h60, 8'hFF, 8'h00, 8'hAD},  // R4
    {32'h0000_0001, 8'h40, 8'h5A, 8'h3C, 8'h3C},  // R5
    {32'h0000_0000, 8'h20, 8'h01, 8'h00, 8'h01}   // R4
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic drive(logic [7:0] d, logic s);
    @(negedge clk_i);
    data_i = d;
    soc_i  = s;
    @(posedge clk_i);
    #1;
    got     = data_o;
    got_soc = soc_o;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    drive(8'h00, 1'b0);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [7:0] ref_crc(logic [31:0] h);
    logic [7:0] c = '0;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ h[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_scr(logic [7:0] d);
    logic [7:0] q;
    for (int i = 7; i >= 0; i--) begin
      q[i] = d[i] ^ hist[42];
      hist = {hist[41:0], q[i]};
    end
    return q;
  endfunction

  task automatic send_cell(logic [31:0] hdr, logic [7:0] oct5, logic [7:0] seed,
                           logic [7:0] exp5, logic scr, int wr_k, logic [7:0] wr_a,
                           logic [7:0] wr_d, string tag);
    for (int k = 0; k < 53; k++) begin
      logic [7:0] b, e;
      if (k < 4)       b = hdr[31-8*k -: 8];
      else if (k == 4) b = oct5;
      else             b = seed + 8'(k * 7);
      if (k == wr_k) begin
        reg_we_i = 1'b1; reg_addr_i = wr_a; reg_wdata_i = wr_d;
      end
      drive(b, k == 0);
      reg_we_i = 1'b0;
      if (k == 0) chk({"R9 soc ", tag}, {7'd0, got_soc}, 8'h01);
      if (k == 1) chk({"R9 soc ", tag}, {7'd0, got_soc}, 8'h00);
      if (k < 4)       e = b;                       // R6
      else if (k == 4) e = exp5;
      else             e = scr ? ref_scr(b) : b;    // R7
      chk(k < 4 ? {"R6 ", tag} : (k == 4 ? tag : {"R7 ", tag}), got, e);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 reset data_o", data_o, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    reg_addr_i = 8'h60; #1 chk("R1 ctl reset", reg_rdata_o, 8'h72);
    reg_addr_i = 8'h62; #1 chk("R1 mask reset", reg_rdata_o, 8'h00);
    reg_addr_i = 8'h61; #1 chk("R1 unused addr", reg_rdata_o, 8'h00);

    // default settings: insert + coset on, mask zero
    send_cell(32'h0000_0001, 8'h00, 8'h10, 8'h52, 1'b0, -1, 8'h0, 8'h0, "R3 default");

    for (int v = 0; v < 6; v++) begin
      wr(8'h60, VEC[v][31:24]);
      wr(8'h62, VEC[v][23:16]);
      send_cell(VEC[v][63:32], VEC[v][15:8], 8'(v), VEC[v][7:0], 1'b0, -1, 8'h0, 8'h0,
                "R2 R4 R5 vector");
    end

    // arbitrary header against independent CRC
    wr(8'h60, 8'h20); wr(8'h62, 8'h00);
    send_cell(32'h1234_5678, 8'h00, 8'h33, ref_crc(32'h1234_5678), 1'b0, -1, 8'h0, 8'h0, "R2 crc");

    // read-back and bit 0
    reg_addr_i = 8'h60; wr(8'h60, 8'hFF); #1 chk("R1 ctl readback", reg_rdata_o, 8'hFE);
    wr(8'h60, 8'h00); #1 chk("R1 ctl readback", reg_rdata_o, 8'h00);

    // scrambler over two cells, history zero since reset
    wr(8'h60, 8'hE0); wr(8'h62, 8'h00);
    hist = '0;
    send_cell(32'hA1B2_C3D4, 8'h00, 8'h5C, 8'h52 ^ ref_crc(32'hA1B2_C3D4) ^ 8'h52 ^ 8'h55,
              1'b1, -1, 8'h0, 8'h0, "R7 scr cell1");
    send_cell(32'h0000_0001, 8'h00, 8'hC3, 8'h52, 1'b1, -1, 8'h0, 8'h0, "R8 scr cell2");

    // mid-cell write: current cell unaffected, next cell takes it
    wr(8'h60, 8'h60); wr(8'h62, 8'h00);
    send_cell(32'h0000_0001, 8'h00, 8'h01, 8'h52, 1'b0, 2, 8'h62, 8'hFF, "R11 same cell");
    send_cell(32'h0000_0001, 8'h00, 8'h02, 8'hAD, 1'b0, -1, 8'h0, 8'h0, "R11 next cell");
    send_cell(32'h0000_0001, 8'h00, 8'h03, 8'hAD, 1'b1 & 1'b0, 30, 8'h60, 8'h20, "R11 ctl mid");
    send_cell(32'h0000_0001, 8'h00, 8'h04, 8'h07 ^ 8'hFF, 1'b0, -1, 8'h0, 8'h0, "R11 ctl next");

    // mid-cell start-of-cell resync
    wr(8'h62, 8'h00);
    drive(8'hAA, 1'b1);
    for (int k = 0; k < 19; k++) drive(8'h11, 1'b0);
    send_cell(32'h0000_0001, 8'h00, 8'h05, 8'h07, 1'b0, -1, 8'h0, 8'h0, "R10 resync");

    summary();
  end
endmodule